// File: doc/BRIEF.md
# Debug Trace Buffer Controller

This block captures a stream of processor trace packets into a circular store of 64 entries so that a debugger can read back the recent execution history after the fact. Recording is armed by an enable, begins on a start trigger and ends on a stop trigger. A two-bit status output reports which of these phases the buffer is in.

The write address tells the debugger where the next packet will go. Its top bit is a sticky wrap flag. With the flag clear, the valid entries are index 0 up to the address minus one. With the flag set, the whole store is valid: the oldest entry sits at the address, and the newest sits just below it. The address survives the stop trigger, a disable and a system reset, so the captured history can still be read afterwards.

In obtrusive mode the buffer never overwrites. When the last slot is filled, the block raises a halt request to the CPU. That request stays up until the buffer is reset.

Top module: `trace_buf_ctrl`

## Requirements
- R1: After `rst_n` is low at a clock edge, `state` is 00, `wr_addr` is 0 and `halt_req` is 0. The status codes are:
  - 00: off.
  - 01: armed and waiting for the start trigger.
  - 10: recording and waiting for the stop trigger.
  - 11: recording finished.
- R1 (transitions): A rising `trc_en` moves the status to 01. The start trigger moves 01 to 10. The stop trigger moves 10 to 11. Status 11 holds.
- R2: A packet is stored only while the status is 10. The packet goes to the slot given by the low six address bits, and the address then increments by one. Packets offered in any other status leave `wr_addr` unchanged. Bit 6 of `wr_addr` is always 0.
- R3: A packet offered in the same cycle as the stop trigger is still stored, and the status becomes 11. Later packets are not stored.
- R4: The wrap flag is `wr_addr` bit 7. It is set when a write fills slot 63, and it then stays set until a buffer reset event. While it is set, reading from slot `wr_addr[5:0]` upward, modulo 64, returns the entries from oldest to newest.
- R5: Dropping `trc_en` forces the status to 00 and leaves `wr_addr` unchanged. A `sys_rst` pulse forces the status to 00 and leaves `wr_addr` unchanged. After `sys_rst`, an enable that is still high does not re-arm the buffer; only a fresh rising edge does.
- R6: Three events count as a buffer reset event:
  - a `buf_rst` pulse;
  - a rising edge of `trc_en`;
  - `go_cmd` while `obtr_mode` is 1.

  A buffer reset event clears `wr_addr` and `halt_req`. It sets the status to 01 if `trc_en` is high, and to 00 otherwise.
- R7: `go_cmd` while `obtr_mode` is 0 has no effect on the status or on `wr_addr`.
- R8: In obtrusive mode, the write that fills slot 63 sets `halt_req`, leaving `wr_addr` at 0x80. No further packets are stored while `halt_req` is set.
- R9: `rd_data` shows the entry at the `rd_idx` value sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset, clears all state |
| sys_rst | input | 1 | System reset pulse; returns status to off, keeps the address |
| trc_en | input | 1 | Buffer enable; a rising edge resets and arms the buffer |
| obtr_mode | input | 1 | Obtrusive mode: halt the CPU on full instead of overwriting |
| start_trig | input | 1 | Start trigger |
| stop_trig | input | 1 | Stop trigger |
| buf_rst | input | 1 | One-cycle buffer reset command |
| go_cmd | input | 1 | Debugger resume command; a reset event only in obtrusive mode |
| pkt_valid | input | 1 | Trace packet present |
| pkt_data | input | DATA_W | Trace packet |
| rd_idx | input | PTR_W | Read slot index |
| rd_data | output | DATA_W | Entry at the index sampled at the previous edge |
| state | output | 2 | Recording status |
| wr_addr | output | ADDR_W | Next write slot; bit 7 is the wrap flag |
| halt_req | output | 1 | CPU halt request in obtrusive mode |

## Verification
The wrapped and halted conditions can only be reached by pushing at least 64 packets through the recording state. The bench does this with long packet runs of distinct values. It then walks the whole store, starting from the write address, against a reference array kept from the requirements. The survival of the address across a system reset is also hard to observe. To see it, the bench holds the enable high through the reset pulse and checks that nothing re-arms until a fresh rising edge.

// File: rtl/tbc_pkg.sv
// Shared types for the trace buffer controller.
// Assumes: the status encoding is visible to software and must not change.
package tbc_pkg;
    typedef enum logic [1:0] {
        TB_OFF   = 2'b00,
        TB_ARMED = 2'b01,
        TB_REC   = 2'b10,
        TB_DONE  = 2'b11
    } tb_state_e;
endpackage

// File: rtl/tbc_arm_fsm.sv
// Recording status machine.
// It tracks the enable edge, decodes the buffer reset events and qualifies incoming packets.
// Assumes: sys_rst outranks every other control, and a clear event outranks the triggers.
module tbc_arm_fsm
    import tbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sys_rst,
    input  logic      en,
    input  logic      obtr,
    input  logic      start_trig,
    input  logic      stop_trig,
    input  logic      buf_rst,
    input  logic      go_cmd,
    input  logic      pkt_valid,
    output tb_state_e state,
    output logic      clr,
    output logic      rec_slot
);
    logic      en_q;
    logic      en_rise;
    tb_state_e nxt;

    assign en_rise  = en & ~en_q;
    assign clr      = ~sys_rst & (buf_rst | en_rise | (go_cmd & obtr));
    assign rec_slot = ~sys_rst & ~clr & en & (state == TB_REC) & pkt_valid;

    // Next status from the controls and the triggers.
    always_comb begin
        nxt = state;
        if (sys_rst)      nxt = TB_OFF;
        else if (clr)     nxt = en ? TB_ARMED : TB_OFF;
        else if (!en)     nxt = TB_OFF;
        else begin
            case (state)
                TB_ARMED: if (start_trig) nxt = TB_REC;
                TB_REC:   if (stop_trig)  nxt = TB_DONE;
                default:  nxt = state;
            endcase
        end
    end

    // Status register and enable history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TB_OFF;
            en_q  <= 1'b0;
        end else begin
            state <= nxt;
            en_q  <= en;
        end
    end

    // R3
    stop_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TB_REC && stop_trig && en && !sys_rst && !clr) |=> (state == TB_DONE));
    // R1
    done_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TB_DONE && en && !sys_rst && !clr) |=> (state == TB_DONE));
    // R5
    sysrst_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> (state == TB_OFF));
endmodule

// File: rtl/tbc_wr_ptr.sv
// Write pointer, sticky wrap flag and obtrusive halt flag.
// Assumes: DEPTH is a power of two, and ADDR_W leaves at least one always-zero bit between the wrap flag and the pointer.
module tbc_wr_ptr #(
    parameter int PTR_W  = 6,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              obtr,
    input  logic              rec_slot,
    output logic [PTR_W-1:0]  ptr,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              halt,
    output logic              wr_fire
);
    localparam int PAD_W = ADDR_W - 1 - PTR_W;

    logic wrap;
    logic at_last;

    assign wr_fire = rec_slot & ~halt;
    assign at_last = (ptr == {PTR_W{1'b1}});
    assign wr_addr = {wrap, {PAD_W{1'b0}}, ptr};

    // Advance on each stored packet and flag the pass beyond the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ptr  <= '0;
            wrap <= 1'b0;
            halt <= 1'b0;
        end else if (wr_fire) begin
            ptr <= ptr + 1'b1;
            if (at_last) begin
                wrap <= 1'b1;
                if (obtr) halt <= 1'b1;
            end
        end
    end

    // R4
    wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !clr) |=> wrap);
    // R8
    halt_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt && !clr) |=> ($stable(ptr) && halt));
    // R5
    idle_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_slot && !clr) |=> $stable(wr_addr));
endmodule

// File: rtl/tbc_store.sv
// Entry storage: one synchronous write port, and a read port with a registered index.
// Assumes: the contents are not cleared by any reset, so history can be read back later.
module tbc_store #(
    parameter int DATA_W = 8,
    parameter int PTR_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [PTR_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << PTR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  idx_q;

    // Store the qualified packet.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Capture the read index.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= rd_idx;
    end

    assign rd_data = mem[idx_q];
endmodule

// File: rtl/trace_buf_ctrl.sv
// Top of the debug trace buffer controller.
// It ties together the status machine, the write pointer and the entry store.
// Assumes: every control input is synchronous to clk.
module trace_buf_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 8,
    parameter int PTR_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_rst,
    input  logic              trc_en,
    input  logic              obtr_mode,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic              buf_rst,
    input  logic              go_cmd,
    input  logic              pkt_valid,
    input  logic [DATA_W-1:0] pkt_data,
    input  logic [PTR_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        state,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              halt_req
);
    import tbc_pkg::*;

    tb_state_e        st;
    logic             clr;
    logic             rec_slot;
    logic             wr_fire;
    logic [PTR_W-1:0] ptr;

    tbc_arm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .en(trc_en), .obtr(obtr_mode),
        .start_trig(start_trig), .stop_trig(stop_trig), .buf_rst(buf_rst),
        .go_cmd(go_cmd), .pkt_valid(pkt_valid), .state(st), .clr(clr), .rec_slot(rec_slot)
    );

    tbc_wr_ptr #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .clr(clr), .obtr(obtr_mode), .rec_slot(rec_slot),
        .ptr(ptr), .wr_addr(wr_addr), .halt(halt_req), .wr_fire(wr_fire)
    );

    tbc_store #(.DATA_W(DATA_W), .PTR_W(PTR_W)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(wr_fire), .waddr(ptr), .wdata(pkt_data),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    assign state = st;

    // R2
    no_write_outside_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != TB_REC && !clr) |=> $stable(wr_addr));
    // R2
    pad_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_addr[ADDR_W-2] == 1'b0);
    // R6
    clear_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (wr_addr == '0 && !halt_req));
endmodule

// File: tb/trace_buf_ctrl_test.sv
// Directed bench for trace_buf_ctrl. Each task drives one scenario and checks its results.
module trace_buf_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, sys_rst = 1'b0, trc_en = 1'b0, obtr_mode = 1'b0;
    logic       start_trig = 1'b0, stop_trig = 1'b0, buf_rst = 1'b0, go_cmd = 1'b0;
    logic       pkt_valid = 1'b0;
    logic [7:0] pkt_data = '0;
    logic [5:0] rd_idx = '0;
    logic [7:0] rd_data;
    logic [1:0] state;
    logic [7:0] wr_addr;
    logic       halt_req;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] ref_mem [64];
    int         m_ptr = 0;
    bit         m_wrap = 0;
    bit         m_halt = 0;
    logic [7:0] dval = 8'h10;

    trace_buf_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst), .trc_en(trc_en), .obtr_mode(obtr_mode),
        .start_trig(start_trig), .stop_trig(stop_trig), .buf_rst(buf_rst), .go_cmd(go_cmd),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .rd_idx(rd_idx), .rd_data(rd_data),
        .state(state), .wr_addr(wr_addr), .halt_req(halt_req)
    );

    always #10 clk = ~clk;

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_addr();
        return {m_wrap, 1'b0, 6'(m_ptr)};
    endfunction

    function automatic void model_clear();
        m_ptr = 0; m_wrap = 0; m_halt = 0;
    endfunction

    // Offer n packets; update the model only when recording is expected.
    task automatic push(int n, bit stored);
        for (int i = 0; i < n; i++) begin
            pkt_valid = 1'b1;
            pkt_data  = dval;
            if (stored && !m_halt) begin
                ref_mem[m_ptr] = dval;
                if (m_ptr == 63) begin
                    m_wrap = 1;
                    if (obtr_mode) m_halt = 1;
                end
                m_ptr = (m_ptr + 1) % 64;
            end
            dval = dval + 8'd1;
            tick();
        end
        pkt_valid = 1'b0;
    endtask

    task automatic pulse_start();
        start_trig = 1'b1; tick(); start_trig = 1'b0;
    endtask

    // Read n slots from `first` upward and compare each with the model.
    task automatic readback(int first, int n, string req);
        for (int k = 0; k < n; k++) begin
            rd_idx = 6'((first + k) % 64);
            tick();
            chk(req, rd_data, ref_mem[(first + k) % 64]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; repeat (3) tick(); rst_n = 1'b1; tick();
        chk("R1 reset state", state, 2'b00);
        chk("R1 reset addr", wr_addr, 8'h00);
        chk("R1 reset halt", halt_req, 1'b0);
    endtask

    task automatic t_arm_record();
        trc_en = 1'b1; tick(); model_clear();
        chk("R1 armed", state, 2'b01);
        push(2, 0);
        chk("R2 no write while armed", wr_addr, 8'h00);
        pulse_start();
        chk("R1 recording", state, 2'b10);
        push(10, 1);
        chk("R2 addr after 10", wr_addr, exp_addr());
        chk("R2 still recording", state, 2'b10);
        readback(0, 10, "R9 readback");
        // Read latency: the output follows the index sampled at the previous edge.
        rd_idx = 6'd3; tick();
        rd_idx = 6'd7; #1;
        chk("R9 latency old", rd_data, ref_mem[3]);
        tick();
        chk("R9 latency new", rd_data, ref_mem[7]);
    endtask

    task automatic t_stop();
        stop_trig = 1'b1;
        push(1, 1);
        stop_trig = 1'b0;
        chk("R3 done state", state, 2'b11);
        chk("R3 stop packet stored", wr_addr, exp_addr());
        push(3, 0);
        chk("R3 no write after stop", wr_addr, exp_addr());
        chk("R1 done holds", state, 2'b11);
        readback(0, m_ptr, "R3 readback");
    endtask

    task automatic t_hold();
        sys_rst = 1'b1; tick(); sys_rst = 1'b0;
        chk("R5 sysrst state", state, 2'b00);
        chk("R5 sysrst addr kept", wr_addr, exp_addr());
        repeat (3) tick();
        chk("R5 no rearm after sysrst", state, 2'b00);
        chk("R5 addr still kept", wr_addr, exp_addr());
        trc_en = 1'b0; tick();
        chk("R5 disable state", state, 2'b00);
        chk("R5 disable addr kept", wr_addr, exp_addr());
        readback(0, m_ptr, "R5 readback after disable");
        trc_en = 1'b1; tick(); model_clear();
        chk("R6 enable rise addr", wr_addr, 8'h00);
        chk("R6 enable rise state", state, 2'b01);
    endtask

    task automatic t_wrap();
        pulse_start();
        push(70, 1);
        chk("R4 wrapped addr", wr_addr, 8'h86);
        chk("R4 model addr", wr_addr, exp_addr());
        chk("R4 no halt", halt_req, 1'b0);
        readback(m_ptr, 64, "R4 oldest to newest");
        push(5, 1);
        chk("R4 wrap sticky", wr_addr, exp_addr());
        stop_trig = 1'b1; tick(); stop_trig = 1'b0;
        chk("R3 stopped", state, 2'b11);
    endtask

    task automatic t_bufrst();
        buf_rst = 1'b1; tick(); buf_rst = 1'b0; model_clear();
        chk("R6 bufrst addr", wr_addr, 8'h00);
        chk("R6 bufrst state", state, 2'b01);
    endtask

    task automatic t_go_plain();
        pulse_start();
        push(5, 1);
        go_cmd = 1'b1; tick(); go_cmd = 1'b0;
        chk("R7 go ignored addr", wr_addr, exp_addr());
        chk("R7 go ignored state", state, 2'b10);
    endtask

    task automatic t_obtrusive();
        obtr_mode = 1'b1;
        go_cmd = 1'b1; tick(); go_cmd = 1'b0; model_clear();
        chk("R6 go obtr addr", wr_addr, 8'h00);
        chk("R6 go obtr state", state, 2'b01);
        pulse_start();
        push(63, 1);
        chk("R8 before full addr", wr_addr, 8'h3f);
        chk("R8 before full halt", halt_req, 1'b0);
        push(1, 1);
        chk("R8 full halt", halt_req, 1'b1);
        chk("R8 full addr", wr_addr, 8'h80);
        push(3, 1);
        chk("R8 frozen addr", wr_addr, 8'h80);
        readback(0, 64, "R8 no overwrite");
        go_cmd = 1'b1; tick(); go_cmd = 1'b0; model_clear();
        chk("R6 go clears halt", halt_req, 1'b0);
        chk("R6 go clears addr", wr_addr, 8'h00);
        chk("R6 go state", state, 2'b01);
        obtr_mode = 1'b0;
        trc_en = 1'b0; tick();
        buf_rst = 1'b1; tick(); buf_rst = 1'b0;
        chk("R6 bufrst while off", state, 2'b00);
    endtask

    initial begin
        t_reset();
        t_arm_record();
        t_stop();
        t_hold();
        t_wrap();
        t_bufrst();
        t_go_plain();
        t_obtrusive();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule